// File: doc/BRIEF.md
# Strobed single-bit static RAM

This block is a clocked model of a small static memory with 64 one-bit words. Each cycle it samples a 6-bit address, a strobe, two chip enables, a read/write select and a data bit. An access takes place only in a cycle where the strobe and both enables are high together. A read drives an output-enable flag that stands in for a three-state pin. The returned bit goes through three steps: the output is first disabled, then driven low, then it shows the stored bit. A write keeps the output disabled. It holds the address and data until the write access ends, then commits them.

The read latency is the parameter `READ_LAT`, in clock cycles, and must be 3 or more. Several blocks can share one result line by OR-ing each `dout` gated by its own `dout_oe`. A wider word is built by running blocks in parallel with their address and control inputs tied together. A deeper memory uses decoded upper address bits to gate the strobe of each block. The interface is plain and is sampled on every clock. The block applies no back-pressure, so it needs no valid/ready pair.

Top module: `strobed_bit_ram`

## Requirements
- R1: An access is qualified only in a cycle where `strobe`, `ce_a` and `ce_b` are all 1. In the cycle after any edge that samples one of them at 0, `dout_oe` is 0.
- R2: A qualified access with `rd_nwr`=0 is a write. In the cycle after it is sampled, `dout_oe` is 0.
- R3: The first qualified read edge gives `dout_oe`=0 in the following cycle. Any qualified read edge whose address differs from the one sampled at the edge before also counts as a first read.
- R4: Count consecutive qualified read edges at one unchanged address. After counts 2 to `READ_LAT`-1, `dout_oe` is 1 and `dout` is 0.
- R5: From count `READ_LAT` onward, `dout_oe` is 1 and `dout` equals the stored bit at that address, with no inversion. The output holds this value for as long as the read continues.
- R6: If the address changes while the memory is strobed for reading, the count restarts. The next cycle shows `dout_oe`=0, and valid data returns only after `READ_LAT` further edges.
- R7: A write is committed on the first edge that does not sample a qualified write to the same address. This happens when the qualifier falls, when `rd_nwr` rises, or when the address changes. The bit stored is the `din` sampled at the last write edge of that access.
- R8: Back-to-back writes to different addresses, with `rd_nwr` held low and no idle cycle between them, each store their own bit.
- R9: While `rst_n` is 0, and in the cycle after it is released, `dout_oe` and `dout` are 0. Memory contents are not initialised.
- R10: `dout` is 0 whenever `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Word address, fully decoded |
| strobe | input | 1 | Access strobe |
| ce_a | input | 1 | First chip enable |
| ce_b | input | 1 | Second chip enable |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when not enabled |
| dout_oe | output | 1 | Output-enable flag standing in for the three-state driver |

## Verification
Directed patterns are used first:
- A back-to-back write of all 64 words followed by a held read of each word. This separates a correct decode and commit from aliasing or lost writes.
- A read with one enable low, which exposes wrong gating.
- An address hop in the middle of a read, which exposes a count that fails to restart.
- A write whose data bit changes before the strobe falls, which tells a commit at the end of the access from a commit on the first cycle.

After that, a seeded random stream runs with sticky addresses and sticky read/write values. It mixes short and long reads, write-to-read turnarounds and dropped enables. Every cycle it checks the enable phase and the data against a model in the bench.

// File: rtl/strobed_ram_pkg.sv
package strobed_ram_pkg;

  // Read output phase derived from the consecutive-read count.
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_BLANK = 2'd1,
    RD_LOW   = 2'd2,
    RD_DATA  = 2'd3
  } rd_phase_e;

  // Decoded access kind for one sampled cycle.
  typedef struct packed {
    logic rd;
    logic wr;
  } access_t;

endpackage

// File: rtl/strobe_qual.sv
module strobe_qual
  import strobed_ram_pkg::*;
(
  input  logic    strobe,
  input  logic    ce_a,
  input  logic    ce_b,
  input  logic    rd_nwr,
  output access_t acc
);

  logic hit;

  always_comb begin
    hit    = strobe & ce_a & ce_b;
    acc.rd = hit & rd_nwr;
    acc.wr = hit & ~rd_nwr;
  end

endmodule

// File: rtl/bit_store.sv
module bit_store #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_bit;
  end

  assign rd_bit = cells[rd_addr];

endmodule

// File: rtl/wr_hold.sv
module wr_hold #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic              c_bit
);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_bit_q;
  logic              continues;

  always_comb begin
    continues = swrite && (addr == pend_addr_q);
    commit    = pend_q && !continues;
    c_addr    = pend_addr_q;
    c_bit     = pend_bit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_bit_q  <= 1'b0;
    end else begin
      pend_q <= swrite;
      if (swrite) begin
        pend_addr_q <= addr;
        pend_bit_q  <= din;
      end
    end
  end

  // R7
  commit_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(commit));

  // R8
  hop_commits_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && swrite && addr != pend_addr_q) |-> commit);

endmodule

// File: rtl/rd_timer.sv
module rd_timer
  import strobed_ram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int READ_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sread,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rbit,
  output logic              dout,
  output logic              dout_oe
);

  localparam int CNT_W = $clog2(READ_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(READ_LAT);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_act_q;
  logic              same;
  rd_phase_e         phase_d;

  always_comb begin
    same = rd_act_q && (addr == addr_q);
    if (!sread)              cnt_d = '0;
    else if (!same)          cnt_d = ONE_C;
    else if (cnt_q == LAT_C) cnt_d = LAT_C;
    else                     cnt_d = cnt_q + ONE_C;

    if (cnt_d == '0)         phase_d = RD_IDLE;
    else if (cnt_d == ONE_C) phase_d = RD_BLANK;
    else if (cnt_d == LAT_C) phase_d = RD_DATA;
    else                     phase_d = RD_LOW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      addr_q   <= '0;
      rd_act_q <= 1'b0;
      dout_oe  <= 1'b0;
      dout     <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      addr_q   <= addr;
      rd_act_q <= sread;
      dout_oe  <= (phase_d == RD_LOW) || (phase_d == RD_DATA);
      dout     <= (phase_d == RD_DATA) && rbit;
    end
  end

  // R3
  first_read_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sread && !same) |=> !dout_oe);

  // R4
  low_phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && cnt_q != LAT_C) |-> !dout);

  // R5
  data_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sread && same && cnt_q == LAT_C) |=> (dout_oe && dout == $past(rbit)));

endmodule

// File: rtl/strobed_bit_ram.sv
module strobed_bit_ram
  import strobed_ram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int READ_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              ce_a,
  input  logic              ce_b,
  input  logic              rd_nwr,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe
);

  access_t           acc;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic              c_bit;
  logic              rbit;

  strobe_qual u_qual (
    .strobe (strobe),
    .ce_a   (ce_a),
    .ce_b   (ce_b),
    .rd_nwr (rd_nwr),
    .acc    (acc)
  );

  wr_hold #(.ADDR_W(ADDR_W)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .swrite (acc.wr),
    .addr   (addr),
    .din    (din),
    .commit (commit),
    .c_addr (c_addr),
    .c_bit  (c_bit)
  );

  bit_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (c_addr),
    .wr_bit  (c_bit),
    .rd_addr (addr),
    .rd_bit  (rbit)
  );

  rd_timer #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .sread   (acc.rd),
    .addr    (addr),
    .rbit    (rbit),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  // R1
  unqualified_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && ce_a && ce_b) |=> !dout_oe);

  // R2
  write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ce_a && ce_b && !rd_nwr) |=> !dout_oe);

  // R10
  dout_zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);

endmodule

// File: tb/strobed_bit_ram_bench.sv
module strobed_bit_ram_bench;

  localparam int CLK_P    = 10;
  localparam int ADDR_W   = 6;
  localparam int READ_LAT = 4;
  localparam int DEPTH    = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              strobe, ce_a, ce_b, rd_nwr, din;
  logic              dout, dout_oe;

  int checks = 0;
  int errors = 0;
  string cur_tag = "";

  // bench model
  logic [DEPTH-1:0]  m_mem;
  logic [DEPTH-1:0]  m_known;
  logic              m_pend;
  logic [ADDR_W-1:0] m_waddr;
  logic              m_wbit;
  logic              m_ract;
  logic [ADDR_W-1:0] m_raddr;
  int                m_cnt;

  always #(CLK_P/2) clk = ~clk;

  strobed_bit_ram #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) u_strobed_bit_ram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe), .ce_a(ce_a),
    .ce_b(ce_b), .rd_nwr(rd_nwr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic pat(input logic [ADDR_W-1:0] a);
    return a[0] ^ a[3] ^ a[5] ^ a[1];
  endfunction

  function automatic string phase_tag(input int c);
    if (c == 0) return "R2";
    if (c == 1) return "R3";
    if (c < READ_LAT) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [ADDR_W-1:0] a, input logic s, input logic e1,
                      input logic e2, input logic rw, input logic d);
    logic sq, sr, sw, same, exp_oe, exp_d;
    string tag;
    @(negedge clk);
    addr = a; strobe = s; ce_a = e1; ce_b = e2; rd_nwr = rw; din = d;
    @(posedge clk);
    sq = s & e1 & e2;
    sr = sq & rw;
    sw = sq & ~rw;
    if (m_pend && !(sw && a == m_waddr)) begin
      m_mem[m_waddr]   = m_wbit;
      m_known[m_waddr] = 1'b1;
    end
    m_pend = sw;
    if (sw) begin m_waddr = a; m_wbit = d; end
    same = m_ract && (a == m_raddr);
    if (!sr) m_cnt = 0;
    else if (!same) m_cnt = 1;
    else if (m_cnt < READ_LAT) m_cnt = m_cnt + 1;
    m_ract = sr;
    m_raddr = a;
    exp_oe = (m_cnt >= 2);
    exp_d  = (m_cnt == READ_LAT) ? m_mem[a] : 1'b0;
    tag = (cur_tag != "") ? cur_tag : phase_tag(m_cnt);
    #(CLK_P/4);
    check(tag, dout_oe, exp_oe, "dout_oe");
    if (m_cnt != READ_LAT || m_known[a]) check(tag, dout, exp_d, "dout");
    if (!dout_oe) check("R10", dout, 1'b0, "dout while disabled");
  endtask

  task automatic idle();
    step(addr, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic hold_read(input logic [ADDR_W-1:0] a, input int n);
    for (int i = 0; i < n; i++) step(a, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] ra;
    logic rrw;
    int unused_seed;
    m_mem = '0; m_known = '0; m_pend = 1'b0; m_waddr = '0; m_wbit = 1'b0;
    m_ract = 1'b0; m_raddr = '0; m_cnt = 0;
    addr = '0; strobe = 1'b1; ce_a = 1'b1; ce_b = 1'b1; rd_nwr = 1'b1; din = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R9: reset state with a read request pending
    check("R9", dout_oe, 1'b0, "dout_oe in reset");
    check("R9", dout, 1'b0, "dout in reset");
    @(negedge clk);
    strobe = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #(CLK_P/4);
    check("R9", dout_oe, 1'b0, "dout_oe after release");

    // R8: write every word back to back, rd_nwr held low
    cur_tag = "R8";
    for (int a = 0; a < DEPTH; a++) step(ADDR_W'(a), 1'b1, 1'b1, 1'b1, 1'b0, pat(ADDR_W'(a)));
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      hold_read(ADDR_W'(a), READ_LAT + 1);
      idle();
    end
    cur_tag = "";

    // R3 R4 R5: one long read
    hold_read(6'd5, READ_LAT + 4);
    idle();

    // R1: each enable low in turn blocks the read
    cur_tag = "R1";
    for (int i = 0; i < READ_LAT + 2; i++) step(6'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < READ_LAT + 2; i++) step(6'd7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < READ_LAT + 2; i++) step(6'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    cur_tag = "";

    // R6: address hop during a strobed read
    hold_read(6'd9, READ_LAT + 1);
    cur_tag = "R6";
    hold_read(6'd10, READ_LAT + 1);
    cur_tag = "";
    idle();

    // R7: data changes while writing; the last sampled bit is stored
    cur_tag = "R7";
    step(6'd3, 1'b1, 1'b1, 1'b1, 1'b0, ~pat(6'd3));
    step(6'd3, 1'b1, 1'b1, 1'b1, 1'b0, pat(6'd3));
    step(6'd3, 1'b1, 1'b1, 1'b1, 1'b0, ~pat(6'd3));
    // write turns straight into a read of the same word
    hold_read(6'd3, READ_LAT + 1);
    step(6'd4, 1'b1, 1'b1, 1'b1, 1'b0, ~pat(6'd4));
    step(6'd4, 1'b1, 1'b0, 1'b1, 1'b0, pat(6'd4));
    hold_read(6'd4, READ_LAT + 1);
    cur_tag = "";
    idle();

    // random traffic
    unused_seed = $urandom(32'h5eed);
    ra = 6'd0; rrw = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 4) == 0) ra = ADDR_W'($urandom);
      if (($urandom % 6) == 0) rrw = ~rrw;
      step(ra, ($urandom % 8) != 0, ($urandom % 10) != 0, ($urandom % 10) != 0,
           rrw, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule